// File: doc/BRIEF.md
# Pulse-Counting Interrupt Channels

This block serves a set of external input pins, four by default. Each pin feeds its own channel, and each channel works in one of two modes. In plain mode, every rising edge of the pin raises a one-cycle interrupt request. In counter mode, the channel counts rising edges and raises a request after a programmed number of them. It then reloads itself, so the requests repeat with a fixed period.

A host sets up the channels through two strobes:

- A set-value write stores a 16-bit number for one channel.
- A command carries a 2-bit opcode and a select bit for each channel.

The refresh commands copy each selected channel's stored number into its count logic and start it running. The mask command can silence selected channels, and it returns every unselected channel to plain mode.

Pins are first passed through a synchronizer. Only synchronized rising edges are counted. A stored number of zero stops the channel when it is refreshed. A stored number changed while a channel runs takes effect only at the next refresh.

Top module: `pulse_irq_top`

## Requirements
- R1: After reset every set value is 0x0000, every channel is in plain mode and unmasked, and `irq_o` is all zero.
- R2: In plain mode, each rising edge on `pin_i[i]` gives exactly one pulse on `irq_o[i]`. The pin is driven between clock edges, and the pulse is high after the third rising clock edge that follows.
- R3: `cmd_op` 2'b01 (count down) and 2'b10 (count up) are refresh commands. For each channel whose `cmd_sel` bit is 1 and whose set value N is nonzero, they put the channel in counter mode and start it. From then on, every N-th synchronized rising edge gives one pulse on `irq_o[i]`, and the sequence repeats.
- R4: The count-down and count-up refresh forms give the same interrupt period, N edges.
- R5: A refresh of a channel whose set value is 0x0000 stops it. It raises no interrupt on any later edge until it is refreshed with a nonzero value or returned to plain mode.
- R6: Writing a set value (`sv_we`, with channel index `sv_sel`) does not change the period of a running counter. The new value applies only from the next refresh of that channel.
- R7: A refresh of a running channel restarts its count from the beginning. `irq_o[i]` is low in the cycle after the refresh, so refreshing after every edge suppresses all interrupts.
- R8: `cmd_op` 2'b00 (mask) masks every channel whose `cmd_sel` bit is 1. A masked channel raises no interrupt from the cycle after the command until it is refreshed or returned to plain mode.
- R9: The mask command returns every channel whose `cmd_sel` bit is 0 to plain mode, unmasked and with its counter stopped.
- R10: A refresh leaves every channel whose `cmd_sel` bit is 0 unchanged.
- R11: `cmd_op` 2'b11 has no effect on any channel.
- R12: `irq_o[i]` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | External pulse inputs, asynchronous |
| sv_we | input | 1 | Set-value write strobe |
| sv_sel | input | clog2(NUM_CH) | Channel index for the set-value write |
| sv_wdata | input | CNT_W | Set value to store |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 mask, 01 refresh down, 10 refresh up, 11 no operation |
| cmd_sel | input | NUM_CH | Per-channel select bits of the command |
| irq_o | output | NUM_CH | One-cycle interrupt pulse per channel |

## Verification
The bench builds the block with its defaults: four channels, 16-bit counts and a two-stage synchronizer. With these values it can sweep set values 1 to 5 in both count directions on every channel, and check the request count after each pulse train against the number of pulses divided by the set value, rounded down. It also refreshes under all sixteen select patterns and checks each channel's request count against the count arithmetic or the plain-mode pass-through. The restart, zero-stop, deferred-write, mask and no-operation cases are each run with short pulse trains whose expected counts are small integers.

// File: rtl/pulse_irq_pkg.sv
package pulse_irq_pkg;
  typedef enum logic [1:0] {
    OP_MASK   = 2'b00,
    OP_REF_DN = 2'b01,
    OP_REF_UP = 2'b10,
    OP_NOP    = 2'b11
  } cmd_op_e;

  typedef enum logic {
    MODE_PLAIN = 1'b0,
    MODE_COUNT = 1'b1
  } chan_mode_e;
endpackage

// File: rtl/pulse_irq_sync.sv
module pulse_irq_sync #(
  parameter int NUM_CH = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] rise_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;
    logic              prev_q;

    always_comb begin
      sync_d = {sync_q[STAGES-2:0], pin_i[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        prev_q <= sync_q[STAGES-1];
      end
    end

    assign rise_o[c] = sync_q[STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/pulse_irq_chan.sv
module pulse_irq_chan
  import pulse_irq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] sv_i,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_sel,
  output logic             run_o,
  output logic             irq_o
);
  chan_mode_e       mode_q, mode_d;
  logic             run_q, run_d;
  logic             up_q, up_d;
  logic             mask_q, mask_d;
  logic [CNT_W-1:0] pv_q, pv_d;
  logic [CNT_W-1:0] rl_q, rl_d;
  logic             irq_q, irq_d;
  logic             hit;
  logic             is_ref, is_mask;
  cmd_op_e          op;

  always_comb begin
    op      = cmd_op_e'(cmd_op);
    is_ref  = cmd_valid && (op == OP_REF_DN || op == OP_REF_UP);
    is_mask = cmd_valid && (op == OP_MASK);
  end

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    up_d   = up_q;
    mask_d = mask_q;
    pv_d   = pv_q;
    rl_d   = rl_q;
    hit    = 1'b0;
    if (is_ref && cmd_sel) begin
      mode_d = MODE_COUNT;
      up_d   = (op == OP_REF_UP);
      rl_d   = sv_i;
      run_d  = (sv_i != '0);
      mask_d = 1'b0;
      pv_d   = (op == OP_REF_UP) ? '0 : sv_i;
    end else if (is_mask && cmd_sel) begin
      mask_d = 1'b1;
    end else if (is_mask) begin
      mode_d = MODE_PLAIN;
      run_d  = 1'b0;
      mask_d = 1'b0;
    end else if (rise_i) begin
      if (mode_q == MODE_PLAIN) begin
        hit = 1'b1;
      end else if (run_q) begin
        if (up_q) begin
          if (pv_q == rl_q - CNT_W'(1)) begin
            hit  = 1'b1;
            pv_d = '0;
          end else begin
            pv_d = pv_q + CNT_W'(1);
          end
        end else begin
          if (pv_q == CNT_W'(1)) begin
            hit  = 1'b1;
            pv_d = rl_q;
          end else begin
            pv_d = pv_q - CNT_W'(1);
          end
        end
      end
    end
    irq_d = hit & ~mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PLAIN;
      run_q  <= 1'b0;
      up_q   <= 1'b0;
      mask_q <= 1'b0;
      pv_q   <= '0;
      rl_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      up_q   <= up_d;
      mask_q <= mask_d;
      pv_q   <= pv_d;
      rl_q   <= rl_d;
      irq_q  <= irq_d;
    end
  end

  assign run_o = run_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/pulse_irq_top.sv
module pulse_irq_top #(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         pin_i,
  input  logic                      sv_we,
  input  logic [$clog2(NUM_CH)-1:0] sv_sel,
  input  logic [CNT_W-1:0]          sv_wdata,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [NUM_CH-1:0]         cmd_sel,
  output logic [NUM_CH-1:0]         irq_o
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [NUM_CH-1:0][CNT_W-1:0] sv_q;
  logic [NUM_CH-1:0]            sv_en;
  logic [NUM_CH-1:0]            rise_w;
  logic [NUM_CH-1:0]            run_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pulse_irq_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (pin_i),
    .rise_o (rise_w)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_comb begin
      sv_en[i] = sv_we && (sv_sel == SEL_W'(i));
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)    sv_q[i] <= '0;
      else if (sv_en[i]) sv_q[i] <= sv_wdata;
    end

    pulse_irq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .rise_i    (rise_w[i]),
      .sv_i      (sv_q[i]),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_sel   (cmd_sel[i]),
      .run_o     (run_w[i]),
      .irq_o     (irq_o[i])
    );
  end
endmodule

// File: rtl/pulse_irq_chk.sv
module pulse_irq_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sv_we,
  input logic                         cmd_valid,
  input logic [1:0]                   cmd_op,
  input logic [NUM_CH-1:0]            cmd_sel,
  input logic [NUM_CH-1:0]            rise_i,
  input logic [NUM_CH-1:0]            run_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] sv_i,
  input logic [NUM_CH-1:0]            irq_i
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i[i] |=> !irq_i[i]); // R12
    AST_IRQ_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i[i] |-> $past(rise_i[i])); // R2
    AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10) && cmd_sel[i]) |=> !irq_i[i]); // R7
    AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10) && cmd_sel[i] && sv_i[i] == '0)
        |=> !run_i[i]); // R5
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b00 && cmd_sel[i]) |=> !irq_i[i]); // R8
    AST_PLAIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b00 && !cmd_sel[i]) |=> !run_i[i]); // R9
  end
  AST_SV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sv_we |=> $stable(sv_i)); // R6
endmodule

bind pulse_irq_top pulse_irq_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .sv_we     (sv_we),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_sel   (cmd_sel),
  .rise_i    (rise_w),
  .run_i     (run_w),
  .sv_i      (sv_q),
  .irq_i     (irq_o)
);

// File: tb/pulse_irq_top_bench.sv
`timescale 1ns/1ps
module pulse_irq_top_bench;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_i = '0;
  logic           sv_we = 1'b0;
  logic [1:0]     sv_sel = '0;
  logic [CW-1:0]  sv_wdata = '0;
  logic           cmd_valid = 1'b0;
  logic [1:0]     cmd_op = 2'b11;
  logic [NCH-1:0] cmd_sel = '0;
  logic [NCH-1:0] irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_cnt [NCH];
  int snap    [NCH];
  int dbl_hits = 0;
  logic [NCH-1:0] irq_prev = '0;

  always #5 clk = ~clk;

  pulse_irq_top u_pulse_irq_top (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sv_we(sv_we), .sv_sel(sv_sel),
    .sv_wdata(sv_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .irq_o(irq_o)
  );

  initial for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        if (irq_o[i]) irq_cnt[i]++;
        if (irq_o[i] && irq_prev[i]) dbl_hits++;
      end
      irq_prev <= irq_o;
    end
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_sv(int ch, int val);
    @(negedge clk);
    sv_we = 1'b1; sv_sel = 2'(ch); sv_wdata = CW'(val);
    @(negedge clk);
    sv_we = 1'b0;
  endtask

  task automatic command(logic [1:0] op, logic [NCH-1:0] sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11; cmd_sel = '0;
  endtask

  task automatic pulses(logic [NCH-1:0] chs, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); pin_i = chs;
      idle(2);        pin_i = '0;
      idle(2);
    end
    idle(6);
  endtask

  task automatic take_snap();
    for (int i = 0; i < NCH; i++) snap[i] = irq_cnt[i];
  endtask

  function automatic int delta(int ch);
    return irq_cnt[ch] - snap[ch];
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1: idle output after reset
    check("R1 irq after reset", int'(irq_o), 0);

    // R2: latency of a plain-mode pulse
    @(negedge clk); pin_i = 4'b0001;
    @(negedge clk); check("R2 latency edge1", int'(irq_o[0]), 0);
    @(negedge clk); check("R2 latency edge2", int'(irq_o[0]), 0);
    @(negedge clk); check("R2 latency edge3", int'(irq_o[0]), 1);
    @(negedge clk); check("R2 latency edge4", int'(irq_o[0]), 0);
    pin_i = '0; idle(4);

    // R2: plain mode counts every edge on all channels
    take_snap();
    pulses(4'b1111, 3);
    for (int c = 0; c < NCH; c++) check("R2 plain count", delta(c), 3);

    // R1/R5: set values reset to zero so refresh stops the channel
    command(2'b01, 4'b1111);
    take_snap();
    pulses(4'b1111, 3);
    for (int c = 0; c < NCH; c++) check("R1 R5 zero set value stops", delta(c), 0);

    // R3/R4: sweep set values, directions and channels
    for (int dir = 1; dir <= 2; dir++) begin
      for (int c = 0; c < NCH; c++) begin
        for (int s = 1; s <= 5; s++) begin
          write_sv(c, s);
          command(2'(dir), 4'(1 << c));
          take_snap();
          pulses(4'(1 << c), 2 * s + 1);
          check(dir == 1 ? "R3 count down period" : "R4 count up period",
                delta(c), (2 * s + 1) / s);
        end
      end
    end

    // R6: new set value deferred until refresh
    write_sv(1, 4);
    command(2'b10, 4'b0010);
    write_sv(1, 2);
    take_snap();
    pulses(4'b0010, 4);
    check("R6 running counter keeps old period", delta(1), 1);
    command(2'b10, 4'b0010);
    take_snap();
    pulses(4'b0010, 4);
    check("R6 new period after refresh", delta(1), 2);

    // R7: refresh restarts the count
    write_sv(0, 3);
    command(2'b01, 4'b0001);
    take_snap();
    pulses(4'b0001, 2);
    command(2'b01, 4'b0001);
    pulses(4'b0001, 2);
    check("R7 restart suppresses", delta(0), 0);
    pulses(4'b0001, 1);
    check("R7 third edge after restart", delta(0), 1);
    take_snap();
    for (int k = 0; k < 6; k++) begin
      pulses(4'b0001, 1);
      command(2'b01, 4'b0001);
    end
    check("R7 continuous refresh never fires", delta(0), 0);

    // R8: mask selected channel, others become plain (R9)
    write_sv(2, 1);
    command(2'b01, 4'b0100);
    take_snap();
    pulses(4'b0100, 2);
    check("R8 before mask", delta(2), 2);
    command(2'b00, 4'b0100);
    take_snap();
    pulses(4'b1111, 3);
    check("R8 masked channel silent", delta(2), 0);
    check("R9 unselected plain ch0", delta(0), 3);
    check("R9 unselected plain ch3", delta(3), 3);

    // R9: mask opcode with zero select returns channel to plain
    command(2'b00, 4'b0000);
    take_snap();
    pulses(4'b0100, 3);
    check("R9 plain after mask with zero select", delta(2), 3);

    // R10: refresh leaves unselected channels alone, all select patterns
    for (int c = 0; c < NCH; c++) write_sv(c, 2);
    for (int sel = 0; sel < 16; sel++) begin
      command(2'b00, 4'b0000);
      command(2'b10, 4'(sel));
      take_snap();
      pulses(4'b1111, 3);
      for (int c = 0; c < NCH; c++)
        check(((sel >> c) & 1) != 0 ? "R10 selected counts" : "R10 unselected plain",
              delta(c), ((sel >> c) & 1) != 0 ? 1 : 3);
    end

    // R11: no-operation opcode changes nothing
    command(2'b00, 4'b0000);
    command(2'b11, 4'b1111);
    take_snap();
    pulses(4'b1111, 2);
    for (int c = 0; c < NCH; c++) check("R11 no-op keeps plain", delta(c), 2);
    command(2'b01, 4'b1111);
    command(2'b11, 4'b1111);
    take_snap();
    pulses(4'b1111, 4);
    for (int c = 0; c < NCH; c++) check("R11 no-op keeps counter", delta(c), 2);

    // R12: never two consecutive high cycles
    write_sv(0, 1);
    command(2'b01, 4'b0001);
    pulses(4'b0001, 4);
    check("R12 consecutive irq cycles", dbl_hits, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule